// File: doc/BRIEF.md
# Two-Wire Register Slave with Persistent 16-bit Pointer

This block is a target on a two-wire serial bus with one clock line and one shared, open-drain data line. It exposes a local register space through a 16-bit address pointer that lives inside the block. It oversamples both bus lines with the system clock. It recognises start, repeated-start and stop conditions. It matches a 7-bit device address, which is a parameter. It then either loads the pointer and writes bytes, or returns bytes read from the pointer.

The pointer is kept between transactions. A master can load it with a write that carries no data, issue a repeated start, and read from that address. It can also open a read directly and continue from wherever earlier traffic left the pointer. The pointer steps by one after every data byte, in either direction, with carry from the low byte into the high byte.

On the register side, the block presents a plain synchronous port. `reg_wr` and `reg_rd` are single-cycle strobes that qualify `reg_addr`. Write data accompanies `reg_wr`. The register file must return `reg_rdata` on the clock after `reg_rd`. This port has no valid/ready handshake and cannot apply back-pressure, because the bus gives the block many system clocks between bytes. Flow control on the serial side is only the acknowledge slot; clock stretching is not used.

Top module: `twowire_reg_slave`

## Requirements
- R1: After reset, `sda_oe` is 0 and neither `reg_wr` nor `reg_rd` is asserted.
- R2: After a start (data falls while clock is high), the first byte is taken MSB first. It holds a 7-bit device address followed by a direction bit (0 = write, 1 = read). When the address equals DEV_ADDR, the block pulls the data line low during the ninth clock of that byte.
- R3: On an address mismatch, the block does not acknowledge. It drives nothing, strobes nothing and leaves the pointer alone until the next start or stop.
- R4: In a write, the two bytes after the address byte load the pointer, high byte first and then low byte. The block acknowledges each of them.
- R5: Every later byte of a write produces one `reg_wr` pulse, with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte. The byte is acknowledged.
- R6: The pointer increments by one, modulo 2^16, after every data byte that is written or read.
- R7: A read that has no address phase returns the byte at the pointer left by earlier transactions.
- R8: In a read, the block drives each bit MSB first and releases the line in the acknowledge slot. An acknowledge from the master makes it fetch and send the byte at the next address. Its drive on the data line changes only while the clock is low.
- R9: A no-acknowledge from the master ends the read. The block drives nothing and issues no `reg_rd` until a start or stop.
- R10: A repeated start after the pointer bytes ends the write and keeps the loaded pointer, so a following read starts there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| reg_addr | output | PTR_W | Current pointer, address for the strobes |
| reg_wr | output | 1 | One-cycle register write strobe |
| reg_wdata | output | 8 | Write data, valid with `reg_wr` |
| reg_rd | output | 1 | One-cycle register read strobe |
| reg_rdata | input | 8 | Read data, due on the clock after `reg_rd` |

## Verification
For a write byte, the write strobe and the pointer increment occur in the same clock. The stored address must therefore be the value before the increment, while the next strobe must see the incremented value. The bench provokes this with bursts that cross a low-byte boundary (0x12FE to 0x1300 and 0x00FB to 0x0104). It logs every strobe address and compares it with an arithmetic count from the loaded start address. Reading those locations back after a dummy write and a repeated start confirms that the data landed at the right addresses.

// File: rtl/twr_pkg.sv
package twr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEVADR,
    ST_PTRHI,
    ST_PTRLO,
    ST_WDATA,
    ST_RDATA,
    ST_HOLD
  } twr_state_e;
endpackage

// File: rtl/twr_sync.sv
module twr_sync #(
  parameter int WIDTH = 2,
  parameter int STAGES = 2,
  parameter logic RST_VAL = 1'b1
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= {WIDTH{RST_VAL}};
    end else begin
      stage_q[0] <= din;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/twr_pointer.sv
module twr_pointer #(
  parameter int PTR_W = 16,
  parameter int BYTE_W = 8
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              load_sel,
  input  logic [BYTE_W-1:0] din,
  input  logic              inc,
  output logic [PTR_W-1:0]  ptr
);
  localparam int LANES = PTR_W / BYTE_W;

  logic [PTR_W-1:0] ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else if (load) ptr_q[int'(load_sel)*BYTE_W +: BYTE_W] <= din;
    else if (inc) ptr_q <= ptr_q + 1'b1;
  end

  assign ptr = ptr_q;

  // R6: a step moves the pointer by exactly one
  assert_ptr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    inc && !load |=> ptr_q == $past(ptr_q) + 1'b1);

  // R4: a load replaces exactly the selected byte lane
  assert_ptr_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> BYTE_W'(ptr_q >> (BYTE_W * int'($past(load_sel)))) == $past(din));

  initial assert (LANES == 2) else $error("pointer must be two bytes wide");
endmodule

// File: rtl/twowire_reg_slave.sv
module twowire_reg_slave
  import twr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h36,
  parameter int PTR_W = 16,
  parameter int SYNC_STAGES = 2
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             sda_oe,
  output logic [PTR_W-1:0] reg_addr,
  output logic             reg_wr,
  output logic [7:0]       reg_wdata,
  output logic             reg_rd,
  input  logic [7:0]       reg_rdata
);
  localparam int BYTE_W = 8;
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  logic scl_s, sda_s, scl_q, sda_q;
  logic scl_rise, scl_fall, start_c, stop_c;

  twr_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({scl_in, sda_in}), .dout({scl_s, sda_s}));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;

  twr_state_e st, nxt_st, nxt_after;
  logic [CNT_W-1:0]  cnt;
  logic              in_ack, rd_pend;
  logic [BYTE_W-1:0] rx_sh, tx_sh;
  logic              rx_state, byte_done, addr_hit, ptr_load, ptr_inc;

  assign rx_state  = (st == ST_DEVADR) || (st == ST_PTRHI) || (st == ST_PTRLO) || (st == ST_WDATA);
  assign byte_done = rx_state && scl_fall && !in_ack && (cnt == CNT_FULL);
  assign addr_hit  = (rx_sh[BYTE_W-1:1] == DEV_ADDR);

  always_comb begin
    case (st)
      ST_DEVADR: nxt_after = rx_sh[0] ? ST_RDATA : ST_PTRHI;
      ST_PTRHI:  nxt_after = ST_PTRLO;
      default:   nxt_after = ST_WDATA;
    endcase
  end

  assign reg_wr    = byte_done && (st == ST_WDATA);
  assign reg_wdata = rx_sh;
  assign reg_rd    = (byte_done && (st == ST_DEVADR) && addr_hit && rx_sh[0]) ||
                     ((st == ST_RDATA) && in_ack && scl_rise && !sda_s);
  assign ptr_load  = byte_done && ((st == ST_PTRHI) || (st == ST_PTRLO));
  assign ptr_inc   = reg_wr || ((st == ST_RDATA) && scl_fall && !in_ack && (cnt == CNT_LAST));

  twr_pointer #(.PTR_W(PTR_W), .BYTE_W(BYTE_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load(ptr_load), .load_sel(st == ST_PTRHI),
    .din(rx_sh), .inc(ptr_inc), .ptr(reg_addr));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      nxt_st  <= ST_IDLE;
      cnt     <= '0;
      in_ack  <= 1'b0;
      rx_sh   <= '0;
      tx_sh   <= '1;
      rd_pend <= 1'b0;
    end else begin
      rd_pend <= reg_rd;
      if (rd_pend) tx_sh <= reg_rdata;
      if (stop_c) begin
        st     <= ST_IDLE;
        in_ack <= 1'b0;
        cnt    <= '0;
      end else if (start_c) begin
        st     <= ST_DEVADR;
        in_ack <= 1'b0;
        cnt    <= '0;
      end else if (rx_state) begin
        if (scl_rise && !in_ack && (cnt < CNT_FULL)) begin
          rx_sh <= {rx_sh[BYTE_W-2:0], sda_s};
          cnt   <= cnt + 1'b1;
        end else if (byte_done) begin
          cnt <= '0;
          if ((st == ST_DEVADR) && !addr_hit) st <= ST_HOLD;
          else begin
            in_ack <= 1'b1;
            nxt_st <= nxt_after;
          end
        end else if (scl_fall && in_ack) begin
          in_ack <= 1'b0;
          st     <= nxt_st;
        end
      end else if (st == ST_RDATA) begin
        if (scl_fall && !in_ack) begin
          if (cnt == CNT_LAST) begin
            in_ack <= 1'b1;
            cnt    <= '0;
          end else begin
            tx_sh <= {tx_sh[BYTE_W-2:0], 1'b1};
            cnt   <= cnt + 1'b1;
          end
        end else if (scl_rise && in_ack && sda_s) begin
          st     <= ST_HOLD;
          in_ack <= 1'b0;
        end else if (scl_fall && in_ack) begin
          in_ack <= 1'b0;
        end
      end
    end
  end

  assign sda_oe = (rx_state && in_ack) || ((st == ST_RDATA) && !in_ack && !tx_sh[BYTE_W-1]);

  // R5: write and read strobes never share a cycle
  assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_wr, reg_rd}));

  // R8: the data-line drive only changes while the clock is low
  assert_sda_when_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_s));

  // R3 / R9: the ignore state is silent on the bus and the register port
  assert_hold_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_HOLD |-> !sda_oe && !reg_wr && !reg_rd);

  // R2: an address acknowledge only follows a matching address byte
  assert_addr_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DEVADR) && in_ack |-> rx_sh[BYTE_W-1:1] == DEV_ADDR);
endmodule

// File: tb/twowire_reg_slave_test.sv
module twowire_reg_slave_test;
  localparam int Q = 8;
  localparam logic [6:0] DEV = 7'h36;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, reg_wr, reg_rd;
  logic [15:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata = 8'h00;
  wire sda_bus = sda_m & ~sda_oe;

  always #2.5 clk = ~clk;

  twowire_reg_slave #(.DEV_ADDR(DEV)) uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus), .sda_oe(sda_oe),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata));

  int vectors = 0, fails = 0, wr_cnt = 0, rd_cnt = 0, edge_viol = 0;
  bit done = 0;
  logic [7:0]  mem [256];
  logic [7:0]  exp_mem [256];
  logic [15:0] wa_log [64];
  logic [7:0]  wd_log [64];
  logic oe_prev = 1'b0;

  initial for (int i = 0; i < 256; i++) begin
    mem[i] = 8'(i * 7 + 3);
    exp_mem[i] = 8'(i * 7 + 3);
  end

  always @(posedge clk) begin
    if (reg_wr) begin
      mem[reg_addr[7:0]] <= reg_wdata;
      wa_log[wr_cnt % 64] <= reg_addr;
      wd_log[wr_cnt % 64] <= reg_wdata;
      wr_cnt <= wr_cnt + 1;
    end
    if (reg_rd) begin
      reg_rdata <= mem[reg_addr[7:0]];
      rd_cnt <= rd_cnt + 1;
    end
    oe_prev <= sda_oe;
    if (rst_n && (sda_oe != oe_prev) && scl_m) edge_viol <= edge_viol + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_rstart;
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ackd);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q);
      scl_m = 1'b1; tick(2 * Q);
      scl_m = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    ackd = (sda_bus == 1'b0);
    tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      scl_m = 1'b1; tick(Q);
      b[i] = sda_bus;
      tick(Q);
      scl_m = 1'b0;
    end
    tick(Q);
    sda_m = give_ack ? 1'b0 : 1'b1; tick(Q);
    scl_m = 1'b1; tick(2 * Q);
    scl_m = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  task automatic write_burst(input logic [15:0] start, input int n, input int seed, input string tag);
    bit a;
    int base;
    base = wr_cnt;
    bus_start;
    send_byte({DEV, 1'b0}, a); check(a, "R2 write address ack", a, 1);
    send_byte(start[15:8], a); check(a, "R4 pointer high ack", a, 1);
    send_byte(start[7:0], a);  check(a, "R4 pointer low ack", a, 1);
    for (int k = 0; k < n; k++) begin
      logic [7:0] d;
      logic [15:0] ea;
      d = 8'(k * 37 + seed);
      ea = start + 16'(k);
      send_byte(d, a);
      check(a, "R5 data ack", a, 1);
      check(wa_log[(base + k) % 64] == ea, {"R6 write address ", tag}, wa_log[(base + k) % 64], ea);
      check(wd_log[(base + k) % 64] == d, "R5 write data", wd_log[(base + k) % 64], d);
      exp_mem[ea[7:0]] = d;
    end
    bus_stop;
    check(wr_cnt == base + n, "R5 write strobe count", wr_cnt, base + n);
  endtask

  initial begin
    bit a;
    logic [7:0] b;
    int wsnap, rsnap;
    tick(4);
    check(sda_oe == 1'b0, "R1 reset sda_oe", sda_oe, 0);
    check(reg_wr == 1'b0, "R1 reset reg_wr", reg_wr, 0);
    check(reg_rd == 1'b0, "R1 reset reg_rd", reg_rd, 0);
    rst_n = 1'b1;
    tick(4);
    check(sda_oe == 1'b0, "R1 idle sda_oe", sda_oe, 0);

    // Write burst crossing the low-byte boundary: pointer ends at 0x1301
    write_burst(16'h12FE, 3, 8'hAA, "carry");

    // R7: current-location reads with no address phase
    bus_start;
    send_byte({DEV, 1'b1}, a); check(a, "R2 read address ack", a, 1);
    recv_byte(1'b0, b); check(b == exp_mem[8'h01], "R7 current read", b, exp_mem[8'h01]);
    bus_stop;
    bus_start;
    send_byte({DEV, 1'b1}, a); check(a, "R2 read address ack", a, 1);
    recv_byte(1'b0, b); check(b == exp_mem[8'h02], "R7 R6 read after increment", b, exp_mem[8'h02]);
    bus_stop;

    // R10 dummy write then sequential read from 0x12FD
    wsnap = wr_cnt;
    bus_start;
    send_byte({DEV, 1'b0}, a); check(a, "R10 address ack", a, 1);
    send_byte(8'h12, a); send_byte(8'hFD, a);
    bus_rstart;
    send_byte({DEV, 1'b1}, a); check(a, "R10 read address ack", a, 1);
    check(wr_cnt == wsnap, "R10 no write strobe", wr_cnt, wsnap);
    for (int k = 0; k < 4; k++) begin
      logic [7:0] ix;
      ix = 8'(8'hFD + k);
      recv_byte(k != 3, b);
      check(b == exp_mem[ix], "R8 R10 sequential read", b, exp_mem[ix]);
    end
    // R9: after NACK the block stays off the line
    rsnap = rd_cnt;
    recv_byte(1'b1, b);
    check(b == 8'hFF, "R9 released after nack", b, 8'hFF);
    check(rd_cnt == rsnap, "R9 no read strobe after nack", rd_cnt, rsnap);
    bus_stop;

    // R3 mismatch: traffic is ignored
    wsnap = wr_cnt;
    bus_start;
    send_byte({7'h37, 1'b0}, a); check(!a, "R3 mismatch no ack", a, 0);
    send_byte(8'h00, a); check(!a, "R3 ignored byte no ack", a, 0);
    send_byte(8'h40, a); check(!a, "R3 ignored byte no ack", a, 0);
    send_byte(8'h99, a); check(!a, "R3 ignored byte no ack", a, 0);
    bus_stop;
    check(wr_cnt == wsnap, "R3 no write strobe", wr_cnt, wsnap);
    bus_start;
    send_byte({DEV, 1'b1}, a);
    recv_byte(1'b0, b); check(b == exp_mem[8'h01], "R3 pointer untouched", b, exp_mem[8'h01]);
    bus_stop;

    // R2/R3 sweep of every device address with the write bit
    for (int ad = 0; ad < 128; ad++) begin
      bus_start;
      send_byte({7'(ad), 1'b0}, a);
      check(a == (7'(ad) == DEV), "R2 R3 address sweep", a, 7'(ad) == DEV);
      bus_stop;
    end

    // Second burst with carry, then read back after a dummy write
    write_burst(16'h00FB, 10, 8'h11, "burst");
    bus_start;
    send_byte({DEV, 1'b0}, a); send_byte(8'h00, a); send_byte(8'hFB, a);
    bus_rstart;
    send_byte({DEV, 1'b1}, a);
    for (int k = 0; k < 10; k++) begin
      logic [7:0] ix;
      ix = 8'(8'hFB + k);
      recv_byte(k != 9, b);
      check(b == exp_mem[ix], "R8 burst read back", b, exp_mem[ix]);
    end
    bus_stop;

    check(edge_viol == 0, "R8 drive change while clock high", edge_viol, 0);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      vectors++;
      fails++;
      $display("FAIL R1 watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule